// File: doc/BRIEF.md
# Flash Sector Program Controller

This block sits on the host side of a byte-wide parallel flash that is rewritten one whole sector at a time. A client starts an operation with a sector number and a choice of completion-detection method. It then streams the sector's bytes in over a valid/ready channel. The controller emits one write strobe per accepted byte, at increasing byte offsets. The external device needs every byte of a sector before it begins its internal program cycle. It also needs each new write strobe to fall within a fixed window after the previous strobe rose, or it closes the load early. For this reason the controller aborts with an error if the client stalls for longer than a guard count.

Once the last byte has been written, the controller repeatedly reads the last byte's address. It finishes in one of two ways. In value mode, the status bit 7 must equal bit 7 of the last byte written; the device returns the inverse of that bit while it is still busy. In toggle mode, bit 6 must read the same on two successive reads; the device flips that bit on every read while busy. If neither condition occurs within a cycle limit, the operation ends with a timeout. Exactly one of done, stall error or timeout is pulsed, and then a new operation may be started.

Stream rules: `in_ready` is high only in cycles where the controller is waiting for the next byte. A byte is taken in a cycle where `in_valid` and `in_ready` are both high. While a strobe is in progress, `in_ready` is low and the client must hold or withdraw its byte. `in_valid` may drop at any time without loss.

Top module: `sector_prog`

## Requirements
- R1: During and straight after reset, all three strobes are high, `in_ready`, `busy`, `done`, `err_stall` and `err_timeout` are low, and `fl_drive` is low.
- R2: `start` is acted on only while `busy` is low. It latches `sector` and `poll_mode` (0 = value mode, 1 = toggle mode) and raises `busy` in the next cycle. A `start` while `busy` is high has no effect on the sector that is written.
- R3: `in_ready` is high exactly in the cycles where the controller waits for a byte, and never while a strobe is active. Each handshake consumes one byte.
- R4: For each accepted byte, `fl_we_n` and `fl_ce_n` go low together with `fl_oe_n` high for WE_LOW_CYC cycles. The accepted byte is on `fl_dout` with `fl_drive` high. `fl_we_n` then stays high for WE_HIGH_CYC cycles with the address and data held.
- R5: Throughout an operation, `fl_addr[15:7]` equals the latched sector. During loading, `fl_addr[6:0]` is the byte offset, counting 0, 1, … 127 in acceptance order.
- R6: Exactly 128 write strobes are issued before any read strobe.
- R7: Counting starts from the cycle `busy` rose, or from the cycle after the most recent `fl_we_n` rising edge. If STALL_LIMIT cycles pass in this count without a handshake while waiting, `err_stall` pulses for one cycle and the block returns to idle with no further strobes. STALL_LIMIT must exceed WE_HIGH_CYC.
- R8: Polling consists of read strobes to offset 127 of the sector. Each read strobe has `fl_ce_n` and `fl_oe_n` low, `fl_we_n` high and `fl_drive` low, and lasts READ_CYC cycles. `fl_din` is sampled in the last of those cycles. Read strobes are separated by GAP_CYC cycles with all strobes high.
- R9: In value mode, `done` pulses in the cycle after a sample whose bit 7 equals bit 7 of byte 127.
- R10: In toggle mode, `done` pulses in the cycle after a sample whose bit 6 equals bit 6 of the previous sample of the same operation. The first sample never completes.
- R11: Counting starts from the first read strobe cycle. If POLL_LIMIT cycles pass in this count without completion, `err_timeout` pulses for one cycle and the block returns to idle.
- R12: Each operation ends with exactly one of `done`, `err_stall` or `err_timeout`, each lasting one cycle with `busy` already low, after which a new `start` is accepted.
- R13: `fl_we_n` and `fl_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| sector | input | 9 | Sector number to program |
| poll_mode | input | 1 | 0 = value (bit 7) completion, 1 = toggle (bit 6) completion |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Controller waiting for a byte |
| in_data | input | 8 | Stream byte |
| fl_addr | output | 16 | Flash address |
| fl_dout | output | 8 | Data driven to the flash |
| fl_drive | output | 1 | Enable for the data bus driver |
| fl_din | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: program cycle completed |
| err_stall | output | 1 | One-cycle pulse: stream stalled, load aborted |
| err_timeout | output | 1 | One-cycle pulse: completion not seen in time |

## Verification
The bench covers several corner cases, each tied to a distinct failure:
- A device that finishes before the first read. A controller that insists on seeing a busy status first would hang until timeout.
- A toggle-mode run in which the first sample must not count. A controller that compares against a stale or reset previous bit would finish one read too early.
- A client that stops after part of the sector. The stall guard must fire at the exact cycle; an off-by-one limit, or a counter that is not restarted at each strobe, shifts the pulse or kills a healthy load that has short gaps.
- A device stuck busy, which must give a timeout and then a clean restart.
- A `start` issued mid-load, which must not retarget the sector.

// File: rtl/sector_prog_pkg.sv
package sector_prog_pkg;

  typedef enum logic [2:0] {
    SP_IDLE = 3'd0,
    SP_WAIT = 3'd1,
    SP_WLO  = 3'd2,
    SP_WHI  = 3'd3,
    SP_PRD  = 3'd4,
    SP_PGAP = 3'd5
  } sp_state_e;

  function automatic int sp_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sp_guard_ctr.sv
// Elapsed-cycle counter with a fixed limit; saturates once expired.
module sp_guard_ctr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sp_poll_judge.sv
// Decides whether one read sample shows the end of the program cycle.
module sp_poll_judge #(
  parameter int VALUE_BIT  = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic       toggle_mode,
  input  logic [7:0] sample,
  input  logic       ref_bit,
  input  logic       prev_tgl,
  input  logic       have_prev,
  output logic       hit
);
  logic value_hit;
  logic toggle_hit;
  logic unused_sample;

  assign value_hit     = (sample[VALUE_BIT] == ref_bit);
  assign toggle_hit    = have_prev && (sample[TOGGLE_BIT] == prev_tgl);
  assign hit           = toggle_mode ? toggle_hit : value_hit;
  assign unused_sample = ^sample;
endmodule

// File: rtl/sp_bus_decode.sv
// Maps controller state onto the flash strobes, address and stream ready.
module sp_bus_decode
  import sector_prog_pkg::*;
#(
  parameter int SECT_BITS = 9,
  parameter int OFS_BITS  = 7
) (
  input  sp_state_e              state,
  input  logic [SECT_BITS-1:0]   sect,
  input  logic [OFS_BITS-1:0]    idx,
  input  logic [7:0]             data,
  output logic [SECT_BITS+OFS_BITS-1:0] addr,
  output logic [7:0]             dout,
  output logic                   drive,
  output logic                   ce_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic                   ready,
  output logic                   busy
);
  logic polling;

  assign polling = (state == SP_PRD) || (state == SP_PGAP);
  assign addr    = polling ? {sect, {OFS_BITS{1'b1}}} : {sect, idx};
  assign dout    = data;
  assign ready   = (state == SP_WAIT);
  assign busy    = (state != SP_IDLE);

  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    drive = 1'b0;
    unique case (state)
      SP_WLO: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        drive = 1'b1;
      end
      SP_WHI: begin
        ce_n  = 1'b0;
        drive = 1'b1;
      end
      SP_PRD: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sector_prog.sv
module sector_prog
  import sector_prog_pkg::*;
#(
  parameter int SECT_BITS   = 9,
  parameter int OFS_BITS    = 7,
  parameter int WE_LOW_CYC  = 8,
  parameter int WE_HIGH_CYC = 8,
  parameter int READ_CYC    = 12,
  parameter int GAP_CYC     = 2,
  parameter int STALL_LIMIT = 12500,
  parameter int POLL_LIMIT  = 1250000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [SECT_BITS-1:0]          sector,
  input  logic                          poll_mode,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [7:0]                    in_data,
  output logic [SECT_BITS+OFS_BITS-1:0] fl_addr,
  output logic [7:0]                    fl_dout,
  output logic                          fl_drive,
  input  logic [7:0]                    fl_din,
  output logic                          fl_ce_n,
  output logic                          fl_we_n,
  output logic                          fl_oe_n,
  output logic                          busy,
  output logic                          done,
  output logic                          err_stall,
  output logic                          err_timeout
);
  localparam int PH_MAX = sp_max(sp_max(WE_LOW_CYC, WE_HIGH_CYC), sp_max(READ_CYC, GAP_CYC));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [OFS_BITS-1:0] IDX_LAST = {OFS_BITS{1'b1}};

  sp_state_e              state;
  logic [PH_W-1:0]        ph_cnt;
  logic [PH_W-1:0]        ph_lim;
  logic                   ph_last;
  logic [OFS_BITS-1:0]    idx;
  logic [SECT_BITS-1:0]   sect_q;
  logic                   mode_q;
  logic [7:0]             data_q;
  logic                   prev_tgl;
  logic                   have_prev;
  logic                   done_q;
  logic                   stall_q;
  logic                   tmo_q;
  logic                   stall_exp;
  logic                   poll_exp;
  logic                   hit;
  logic                   polling;

  assign polling = (state == SP_PRD) || (state == SP_PGAP);

  always_comb begin
    unique case (state)
      SP_WLO:  ph_lim = PH_W'(WE_LOW_CYC - 1);
      SP_WHI:  ph_lim = PH_W'(WE_HIGH_CYC - 1);
      SP_PRD:  ph_lim = PH_W'(READ_CYC - 1);
      SP_PGAP: ph_lim = PH_W'(GAP_CYC - 1);
      default: ph_lim = '0;
    endcase
  end
  assign ph_last = (ph_cnt == ph_lim);

  sp_guard_ctr #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     ((state == SP_IDLE) || (state == SP_WLO)),
    .en      ((state == SP_WAIT) || (state == SP_WHI)),
    .expired (stall_exp)
  );

  sp_guard_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!polling),
    .en      (polling),
    .expired (poll_exp)
  );

  sp_poll_judge u_judge (
    .toggle_mode (mode_q),
    .sample      (fl_din),
    .ref_bit     (data_q[7]),
    .prev_tgl    (prev_tgl),
    .have_prev   (have_prev),
    .hit         (hit)
  );

  sp_bus_decode #(.SECT_BITS(SECT_BITS), .OFS_BITS(OFS_BITS)) u_bus (
    .state (state),
    .sect  (sect_q),
    .idx   (idx),
    .data  (data_q),
    .addr  (fl_addr),
    .dout  (fl_dout),
    .drive (fl_drive),
    .ce_n  (fl_ce_n),
    .we_n  (fl_we_n),
    .oe_n  (fl_oe_n),
    .ready (in_ready),
    .busy  (busy)
  );

  assign done        = done_q;
  assign err_stall   = stall_q;
  assign err_timeout = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SP_IDLE;
      ph_cnt    <= '0;
      idx       <= '0;
      sect_q    <= '0;
      mode_q    <= 1'b0;
      data_q    <= '0;
      prev_tgl  <= 1'b0;
      have_prev <= 1'b0;
      done_q    <= 1'b0;
      stall_q   <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      stall_q <= 1'b0;
      tmo_q   <= 1'b0;
      unique case (state)
        SP_IDLE: begin
          ph_cnt <= '0;
          if (start) begin
            sect_q <= sector;
            mode_q <= poll_mode;
            idx    <= '0;
            state  <= SP_WAIT;
          end
        end
        SP_WAIT: begin
          ph_cnt <= '0;
          if (in_valid) begin
            data_q <= in_data;
            state  <= SP_WLO;
          end else if (stall_exp) begin
            stall_q <= 1'b1;
            state   <= SP_IDLE;
          end
        end
        SP_WLO: begin
          if (ph_last) begin
            ph_cnt <= '0;
            state  <= SP_WHI;
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        SP_WHI: begin
          if (ph_last) begin
            ph_cnt <= '0;
            if (idx == IDX_LAST) begin
              have_prev <= 1'b0;
              state     <= SP_PRD;
            end else begin
              idx   <= idx + OFS_BITS'(1);
              state <= SP_WAIT;
            end
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        SP_PRD: begin
          if (ph_last && hit) begin
            done_q <= 1'b1;
            state  <= SP_IDLE;
          end else if (poll_exp) begin
            tmo_q <= 1'b1;
            state <= SP_IDLE;
          end else if (ph_last) begin
            ph_cnt    <= '0;
            prev_tgl  <= fl_din[6];
            have_prev <= 1'b1;
            state     <= SP_PGAP;
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        SP_PGAP: begin
          if (poll_exp) begin
            tmo_q <= 1'b1;
            state <= SP_IDLE;
          end else if (ph_last) begin
            ph_cnt <= '0;
            state  <= SP_PRD;
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        default: state <= SP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_prog_chk.sv
module sector_prog_chk #(
  parameter int SECT_BITS = 9,
  parameter int OFS_BITS  = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_ready,
  input logic                          busy,
  input logic                          done,
  input logic                          err_stall,
  input logic                          err_timeout,
  input logic [SECT_BITS+OFS_BITS-1:0] fl_addr,
  input logic                          fl_drive,
  input logic                          fl_ce_n,
  input logic                          fl_we_n,
  input logic                          fl_oe_n
);
  localparam int AW = SECT_BITS + OFS_BITS;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R13

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && fl_we_n && fl_ce_n)); // R3

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_drive && !fl_ce_n && fl_oe_n)); // R4

  AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_addr[AW-1:OFS_BITS])); // R5

  AST_READ_LAST_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_addr[OFS_BITS-1:0] == {OFS_BITS{1'b1}} && !fl_drive)); // R8

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_stall, err_timeout})); // R12

  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_stall || err_timeout) |-> (!busy && $fell(busy))); // R12
endmodule

bind sector_prog sector_prog_chk #(.SECT_BITS(SECT_BITS), .OFS_BITS(OFS_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .busy        (busy),
  .done        (done),
  .err_stall   (err_stall),
  .err_timeout (err_timeout),
  .fl_addr     (fl_addr),
  .fl_drive    (fl_drive),
  .fl_ce_n     (fl_ce_n),
  .fl_we_n     (fl_we_n),
  .fl_oe_n     (fl_oe_n)
);

// File: tb/sector_prog_bench.sv
`timescale 1ns/1ps
module sector_prog_bench;
  localparam int WLOW = 3, WHIGH = 2, RDC = 3, GAPC = 2, STALL = 40, PLIM = 600;

  logic clk = 0, rst_n = 0, start = 0, poll_mode = 0, in_valid = 0;
  logic [8:0] sector = '0;
  logic [7:0] in_data = '0, fl_din = '0;
  logic in_ready, fl_drive, fl_ce_n, fl_we_n, fl_oe_n, busy, done, err_stall, err_timeout;
  logic [15:0] fl_addr;
  logic [7:0] fl_dout;

  always #4 clk = ~clk;

  sector_prog #(.WE_LOW_CYC(WLOW), .WE_HIGH_CYC(WHIGH), .READ_CYC(RDC), .GAP_CYC(GAPC),
                .STALL_LIMIT(STALL), .POLL_LIMIT(PLIM)) u_sector_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .sector(sector), .poll_mode(poll_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_drive(fl_drive), .fl_din(fl_din), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .busy(busy), .done(done),
    .err_stall(err_stall), .err_timeout(err_timeout));

  int checks = 0, failures = 0, cyc = 0;
  logic finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  logic [7:0] mem [128];
  logic [7:0] last_w = '0;
  logic tgl = 0, we_prev = 1, oe_prev = 1;
  int nwr = 0, bad_sect = 0, prog_left = 0, prog_cyc = 0;
  bit stuck = 0;
  logic [8:0] exp_sect = '0;

  always @(negedge clk) begin
    if (we_prev == 1'b0 && fl_we_n == 1'b1) begin
      mem[fl_addr[6:0]] = fl_dout;
      last_w = fl_dout;
      if (fl_addr[15:7] != exp_sect) bad_sect++;
      nwr++;
      if (nwr == 128) prog_left = stuck ? -1 : prog_cyc;
    end
    if (oe_prev == 1'b1 && fl_oe_n == 1'b0) tgl = ~tgl;
    if (prog_left > 0) prog_left--;
    fl_din = (prog_left != 0) ? {~last_w[7], tgl, last_w[5:0]} : mem[fl_addr[6:0]];
    we_prev = fl_we_n;
    oe_prev = fl_oe_n;
  end

  // ---------------- behavioural reference of the controller ----------------
  int m_st = 0, m_ph = 0, m_idx = 0, m_since = 0, m_poll = 0;
  logic [8:0] m_sect = '0;
  logic [7:0] m_byte = '0;
  logic m_mode = 0, m_prev = 0, m_have = 0, e_done = 0, e_stall = 0, e_tmo = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_idx = 0; m_sect = '0; m_byte = '0;
      e_done = 0; e_stall = 0; e_tmo = 0;
    end else begin
      e_done = 0; e_stall = 0; e_tmo = 0;
      case (m_st)
        0: if (start) begin
             m_sect = sector; m_mode = poll_mode; m_idx = 0; m_since = 0; m_ph = 0; m_st = 1;
           end
        1: if (in_valid) begin m_byte = in_data; m_ph = 0; m_st = 2; end
           else if (m_since >= STALL - 1) begin e_stall = 1; m_st = 0; end
           else m_since++;
        2: begin
             m_since = 0;
             if (m_ph == WLOW - 1) begin m_ph = 0; m_st = 3; end else m_ph++;
           end
        3: begin
             m_since++;
             if (m_ph == WHIGH - 1) begin
               m_ph = 0;
               if (m_idx == 127) begin m_have = 0; m_poll = 0; m_st = 4; end
               else begin m_idx++; m_st = 1; end
             end else m_ph++;
           end
        4: begin
             bit h;
             h = m_mode ? (m_have && fl_din[6] == m_prev) : (fl_din[7] == m_byte[7]);
             if (m_ph == RDC - 1 && h) begin e_done = 1; m_st = 0; end
             else if (m_poll >= PLIM - 1) begin e_tmo = 1; m_st = 0; end
             else if (m_ph == RDC - 1) begin
               m_ph = 0; m_prev = fl_din[6]; m_have = 1; m_st = 5; m_poll++;
             end else begin m_ph++; m_poll++; end
           end
        5: if (m_poll >= PLIM - 1) begin e_tmo = 1; m_st = 0; end
           else if (m_ph == GAPC - 1) begin m_ph = 0; m_st = 4; m_poll++; end
           else begin m_ph++; m_poll++; end
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (!finished) begin
    chk(fl_we_n == !(m_st == 2), "R4 we_n", fl_we_n, !(m_st == 2));
    chk(fl_ce_n == !(m_st >= 2 && m_st <= 4), "R4 ce_n", fl_ce_n, !(m_st >= 2 && m_st <= 4));
    chk(fl_oe_n == !(m_st == 4), "R8 oe_n", fl_oe_n, !(m_st == 4));
    chk(fl_drive == (m_st == 2 || m_st == 3), "R4 drive", fl_drive, (m_st == 2 || m_st == 3));
    chk(in_ready == (m_st == 1), "R3 in_ready", in_ready, (m_st == 1));
    chk(busy == (m_st != 0), "R2 busy", busy, (m_st != 0));
    chk(!(fl_we_n == 0 && fl_oe_n == 0), "R13 strobes", {fl_we_n, fl_oe_n}, 2'b11);
    if (!fl_ce_n) begin
      logic [15:0] ea;
      ea = (m_st >= 4) ? {m_sect, 7'h7F} : {m_sect, 7'(m_idx)};
      chk(fl_addr == ea, (m_st >= 4) ? "R8 addr" : "R5 addr", fl_addr, ea);
    end
    if (!fl_we_n) chk(fl_dout == m_byte, "R4 dout", fl_dout, m_byte);
    chk(done == e_done, m_mode ? "R10 done" : "R9 done", done, e_done);
    chk(err_stall == e_stall, "R7 err_stall", err_stall, e_stall);
    chk(err_timeout == e_tmo, "R11 err_timeout", err_timeout, e_tmo);
  end

  // ---------------- stimulus ----------------
  logic [7:0] src [128];
  int lcg = 12345;

  task automatic arm(input logic [8:0] s, input int pc, input bit stk);
    exp_sect = s; nwr = 0; bad_sect = 0; prog_cyc = pc; stuck = stk; prog_left = 0;
  endtask

  task automatic launch(input logic [8:0] s, input logic m);
    @(negedge clk); sector = s; poll_mode = m; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic feed(input int n, input bit gaps);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      if (gaps && ((lcg >> 8) % 4 == 0)) in_valid = 0;
      else begin
        in_valid = 1; in_data = src[k];
        if (in_ready) k++;
      end
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wait_result(output int code);
    code = 0;
    for (int i = 0; i < 5000 && code == 0; i++) begin
      @(negedge clk);
      if (done) code = 1; else if (err_stall) code = 2; else if (err_timeout) code = 3;
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== src[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int r;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(fl_we_n && fl_oe_n && fl_ce_n && !fl_drive, "R1 strobes in reset",
        {fl_we_n, fl_oe_n, fl_ce_n, fl_drive}, 4'b1110);
    chk(!in_ready && !busy && !done && !err_stall && !err_timeout, "R1 status in reset",
        {in_ready, busy, done, err_stall, err_timeout}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && fl_we_n && !in_ready, "R1 after reset", {busy, fl_we_n, in_ready}, 3'b010);

    // value mode, continuous stream, stray start mid-load
    for (int i = 0; i < 128; i++) src[i] = 8'(i * 37 + 11);
    arm(9'h0A5, 150, 0);
    launch(9'h0A5, 0);
    fork
      feed(128, 0);
      begin
        repeat (30) @(negedge clk);
        sector = 9'h1FF; start = 1;
        @(negedge clk); start = 0;
      end
    join
    wait_result(r);
    chk(r == 1, "R9 value-mode completion", r, 1);
    chk(nwr == 128, "R6 strobe count", nwr, 128);
    chk(bad_sect == 0, "R2 stray start ignored / R5 sector", bad_sect, 0);
    check_mem("R4 sector contents");

    // toggle mode with gaps in the stream
    for (int i = 0; i < 128; i++) src[i] = 8'(i) ^ 8'hC3;
    arm(9'h003, 90, 0);
    launch(9'h003, 1);
    feed(128, 1);
    wait_result(r);
    chk(r == 1, "R10 toggle-mode completion", r, 1);
    chk(nwr == 128, "R6 strobe count gapped", nwr, 128);
    check_mem("R3 gapped stream contents");

    // stall part way through the sector
    for (int i = 0; i < 128; i++) src[i] = 8'(i + 5);
    arm(9'h055, 50, 0);
    launch(9'h055, 0);
    feed(50, 0);
    wait_result(r);
    chk(r == 2, "R7 stall abort", r, 2);
    repeat (20) @(negedge clk);
    chk(nwr == 50, "R7 no strobes after abort", nwr, 50);
    chk(!busy && !in_ready, "R12 idle after stall", {busy, in_ready}, 0);

    // device never finishes
    for (int i = 0; i < 128; i++) src[i] = 8'(200 - i);
    arm(9'h0F0, 0, 1);
    launch(9'h0F0, 0);
    feed(128, 0);
    wait_result(r);
    chk(r == 3, "R11 timeout", r, 3);

    // restart after timeout; device already finished at the first read
    for (int i = 0; i < 128; i++) src[i] = 8'(255 - i);
    arm(9'h100, 1, 0);
    launch(9'h100, 0);
    feed(128, 0);
    wait_result(r);
    chk(r == 1, "R12 new operation after timeout / R9 first read", r, 1);
    check_mem("R12 contents after restart");
    @(negedge clk);
    chk(!busy && !done, "R12 single pulse", {busy, done}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R12: actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule